// File: doc/BRIEF.md
# SMBus Alert Response Slave

This block is the interrupt half of an SMBus slave. Local event sources raise
a request pulse, and the block pulls an active-low, open-drain alert line
toward the host. The alert is held, not self-clearing. It is dropped only
after the host has run an alert response read, in which this device wins the
bus with its own address.

The block sits behind a bit-level bus front end. That front end supplies the
sampled clock and data lines and single-cycle strobes for Start and Stop
conditions. The block returns a single pull-low request for the data line.
After a Start, the block shifts in the first byte. If that byte is the alert
response address with the read bit set, and an alert is pending, the block
acknowledges it. It then shifts out its 7-bit address, MSB first. While it
sends, it compares each bit with the wired-AND line. A device that sees a
lower address on the line backs off and keeps its alert pending, so the host
can repeat the read.

Top module: `smb_alert_resp`

## Requirements
- R1: During and straight after reset, `alert_n_o` is 1 (alert released) and `sda_drv_o` is 0 (data line not pulled).
- R2: A pulse on any bit of `evt_i` makes `alert_n_o` 0 from the next clock on. It stays 0 until a won alert response read clears it.
- R3: If an alert is pending and the first byte after a Start is 0x19 (address 0001100 followed by read bit 1), the block pulls the data line low for the whole ninth clock (the acknowledge).
- R4: After that acknowledge, the block sends the byte {DEV_ADDR, 1} MSB first. For each 0 bit it pulls the line low. It changes its drive only on the cycle after a clock falling edge.
- R5: If arbitration is not lost, `alert_n_o` returns to 1 one cycle after the rising clock edge of the eighth data bit. The line is released at the next falling edge.
- R6: With no alert pending, an address byte of 0x19 gets no acknowledge, and the block never pulls the line.
- R7: The general call read byte 0x01 and the alert response write byte 0x18 get no acknowledge and leave the alert asserted.
- R8: A data bit sent as 1 but sampled as 0 on a rising clock edge counts as lost arbitration. The block stops driving for the rest of the byte and keeps the alert asserted.
- R9: A Start or Stop strobe during a response releases the data line on the next cycle and keeps the alert asserted. A later full read still succeeds.
- R10: An event pulse in the same cycle as the clearing edge takes priority, so the alert stays asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired-AND value) |
| start_i | input | 1 | One-cycle strobe: Start condition seen |
| stop_i | input | 1 | One-cycle strobe: Stop condition seen |
| evt_i | input | NEVT | Event request pulses, one per source |
| alert_n_o | output | 1 | Alert output, 0 = pull alert line low |
| sda_drv_o | output | 1 | 1 = pull the data line low |

## Verification
On every cycle the assertions check the following properties. A pending alert can only fall back through a won clear. An event always asserts the alert. The block never starts pulling the data line while the clock is high. It only drives the line while its alert is pending. A Start or Stop always frees the line. Only the bench's scenarios show the full exchanges: acknowledge only on the read form of the alert response address, the exact bit pattern returned, and loss and win against a second slave with a lower and then a higher address. They also show abort by Start and by Stop with a later retry, and an event arriving in the same cycle as the clear.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_TX,
    ST_DONE
  } ara_st_e;

  localparam int          BYTE_W   = 8;
  localparam logic [6:0]  ARA_ADDR = 7'b0001100;

endpackage

// File: rtl/smb_scl_edge.sv
module smb_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);

  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
    end
  end

  always_comb begin
    rise_o = scl_i & ~scl_q;
    fall_o = ~scl_i & scl_q;
  end

endmodule

// File: rtl/smb_alert_latch.sv
module smb_alert_latch #(
  parameter int NEVT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            clr_i,
  output logic            pend_o
);

  logic pend_q;
  logic pend_d;
  logic any_evt;
  logic upd_en;

  always_comb begin
    any_evt = |evt_i;
    upd_en  = any_evt | clr_i;
    // set has priority over a clear in the same cycle
    pend_d  = any_evt | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_alert_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic pend_i,
  output logic drv_o,
  output logic clr_o
);

  localparam int                CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_RD   = {ARA_ADDR, 1'b1};
  localparam logic [BYTE_W-1:0] TX_BYTE  = {DEV_ADDR, 1'b1};

  ara_st_e             st_q,   st_d;
  logic [CNT_W-1:0]    cnt_q,  cnt_d;
  logic [BYTE_W-1:0]   sh_q,   sh_d;
  logic [BYTE_W-1:0]   tx_q,   tx_d;
  logic                lost_q, lost_d;
  logic                hi_q,   hi_d;
  logic                drv_q,  drv_d;
  logic                lost_now;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    lost_d   = lost_q;
    hi_d     = hi_q;
    drv_d    = drv_q;
    clr_o    = 1'b0;
    // a released 1 that reads back 0 means another slave is driving
    lost_now = lost_q | (tx_q[BYTE_W-1] & ~sda_i);

    if (start_i) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      drv_d  = 1'b0;
      lost_d = 1'b0;
      hi_d   = 1'b0;
    end else if (stop_i) begin
      st_d  = ST_IDLE;
      drv_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise_i && (cnt_q != CNT_FULL)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall_i && (cnt_q == CNT_FULL)) begin
            if ((sh_q == ARA_RD) && pend_i) begin
              st_d  = ST_ACK;
              drv_d = 1'b1;
              hi_d  = 1'b0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise_i) begin
            hi_d = 1'b1;
          end else if (scl_fall_i && hi_q) begin
            st_d   = ST_TX;
            tx_d   = TX_BYTE;
            cnt_d  = '0;
            lost_d = 1'b0;
            drv_d  = ~TX_BYTE[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (scl_rise_i && (cnt_q != CNT_FULL)) begin
            cnt_d  = cnt_q + CNT_W'(1);
            lost_d = lost_now;
            if ((cnt_q == CNT_LAST) && !lost_now) begin
              clr_o = 1'b1;
            end
          end else if (scl_fall_i) begin
            if (cnt_q == CNT_FULL) begin
              st_d  = ST_DONE;
              drv_d = 1'b0;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              drv_d = ~lost_q & ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_DONE: begin
          drv_d = 1'b0;
        end
        default: begin
          drv_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      lost_q <= 1'b0;
      hi_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      lost_q <= lost_d;
      hi_q   <= hi_d;
      drv_q  <= drv_d;
    end
  end

  assign drv_o = drv_q;

endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NEVT     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [NEVT-1:0] evt_i,
  output logic            alert_n_o,
  output logic            sda_drv_o
);

  logic rst_meta_q;
  logic rst_sync_n;
  logic scl_rise;
  logic scl_fall;
  logic ara_clr;
  logic pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  smb_scl_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .scl_i  (scl_i),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  smb_alert_latch #(
    .NEVT (NEVT)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt_i),
    .clr_i  (ara_clr),
    .pend_o (pend)
  );

  smb_ara_fsm #(
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .pend_i     (pend),
    .drv_o      (sda_drv_o),
    .clr_o      (ara_clr)
  );

  assign alert_n_o = ~pend;

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk #(
  parameter int NEVT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            start_i,
  input logic            stop_i,
  input logic [NEVT-1:0] evt_i,
  input logic            alert_n_o,
  input logic            sda_drv_o,
  input logic            clr
);

  // R2
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n_o && !clr) |=> !alert_n_o);

  // R2
  evt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> !alert_n_o);

  // R4
  drv_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drv_o) |-> $past(!scl_i));

  // R6
  drv_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drv_o |-> !alert_n_o);

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !sda_drv_o);

endmodule

bind smb_alert_resp smb_alert_chk #(
  .NEVT (NEVT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_i     (scl_i),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .evt_i     (evt_i),
  .alert_n_o (alert_n_o),
  .sda_drv_o (sda_drv_o),
  .clr       (ara_clr)
);

// File: tb/sim_smb_alert_resp.sv
`timescale 1ns/1ps
module sim_smb_alert_resp;

  localparam logic [6:0] DEV  = 7'h2A;
  localparam int         NEVT = 3;
  localparam logic [7:0] MINE = {DEV, 1'b1};

  logic clk;
  logic rst_n;
  logic scl, m_low, oth_low, start, stop;
  logic [NEVT-1:0] evt;
  logic sda_line;
  logic alert_n_o, sda_drv_o;

  logic  exp_alert_n, exp_drv;
  string cur_req;
  int    tests, fails;
  logic  mon_en, done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign sda_line = ~(m_low | sda_drv_o | oth_low);

  smb_alert_resp #(.DEV_ADDR(DEV), .NEVT(NEVT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .start_i(start), .stop_i(stop), .evt_i(evt),
    .alert_n_o(alert_n_o), .sda_drv_o(sda_drv_o)
  );

  // per-clock comparison against the reference expectations
  always @(posedge clk) begin
    #2;
    if (mon_en && !done) begin
      tests++;
      if (alert_n_o !== exp_alert_n) begin
        fails++;
        $display("FAIL %s alert_n_o actual=%b expected=%b t=%0t", cur_req, alert_n_o, exp_alert_n, $time);
      end
      tests++;
      if (sda_drv_o !== exp_drv) begin
        fails++;
        $display("FAIL %s sda_drv_o actual=%b expected=%b t=%0t", cur_req, sda_drv_o, exp_drv, $time);
      end
    end
  end

  task automatic ph(input logic s, input logic ml, input logic ol,
                    input logic ed, input logic ea, input logic [NEVT-1:0] ev);
    @(negedge clk);
    scl = s; m_low = ml; oth_low = ol; exp_drv = ed; exp_alert_n = ea; evt = ev;
    if (ev != '0) exp_alert_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      evt = '0;
    end
  endtask

  task automatic pulse_evt(input logic [NEVT-1:0] ev);
    @(negedge clk);
    evt = ev; exp_alert_n = 1'b0;
    @(negedge clk);
    evt = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk);
    m_low = 1'b1; start = 1'b1; exp_drv = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_stop();
    ph(1'b0, 1'b1, 1'b0, 1'b0, exp_alert_n, '0);
    ph(1'b1, 1'b1, 1'b0, 1'b0, exp_alert_n, '0);
    @(negedge clk);
    m_low = 1'b0; stop = 1'b1; exp_drv = 1'b0;
    @(negedge clk);
    stop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one host-side read with the given first byte
  task automatic txn(input logic [7:0] ab, input logic ack, input logic oe,
                     input logic [7:0] ob, input logic late_evt,
                     input int abort_at, input logic abort_start);
    logic ea, lost, obit, ed;
    ea = exp_alert_n;
    lost = 1'b0;
    do_start();
    for (int i = 7; i >= 0; i--) begin
      ph(1'b0, ~ab[i], 1'b0, 1'b0, ea, '0);
      ph(1'b1, ~ab[i], 1'b0, 1'b0, ea, '0);
    end
    ph(1'b0, 1'b0, 1'b0, ack, ea, '0);
    ph(1'b1, 1'b0, 1'b0, ack, ea, '0);
    if (!ack) begin
      do_stop();
      return;
    end
    for (int i = 7; i >= 0; i--) begin
      obit = oe ? ob[i] : 1'b1;
      ed   = !lost && !MINE[i];
      ph(1'b0, 1'b0, ~obit, ed, ea, '0);
      if (!lost && MINE[i] && !obit) lost = 1'b1;
      if (i == 0 && !lost && !late_evt) ea = 1'b1;
      ph(1'b1, 1'b0, ~obit, ed, ea, (i == 0 && late_evt) ? 3'b001 : 3'b000);
      if (i == abort_at) begin
        @(negedge clk);
        if (abort_start) start = 1'b1; else stop = 1'b1;
        m_low = abort_start; oth_low = 1'b0; exp_drv = 1'b0;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        @(negedge clk);
        if (abort_start) do_stop();
        return;
      end
    end
    ph(1'b0, 1'b0, 1'b0, 1'b0, ea, '0);
    ph(1'b1, 1'b0, 1'b0, 1'b0, ea, '0);
    do_stop();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; mon_en = 1'b1;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; oth_low = 1'b0;
    start = 1'b0; stop = 1'b0; evt = '0;
    exp_alert_n = 1'b1; exp_drv = 1'b0;
    cur_req = "R1 reset";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    cur_req = "R2 event raises alert";
    pulse_evt(3'b001);
    repeat (8) @(negedge clk);
    pulse_evt(3'b100);

    cur_req = "R3/R4/R5 won read clears";
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, -1, 1'b0);
    repeat (4) @(negedge clk);

    cur_req = "R6 no pending no ack";
    txn(8'h19, 1'b0, 1'b0, 8'h00, 1'b0, -1, 1'b0);

    cur_req = "R7 general call and write ignored";
    pulse_evt(3'b010);
    txn(8'h01, 1'b0, 1'b0, 8'h00, 1'b0, -1, 1'b0);
    txn(8'h18, 1'b0, 1'b0, 8'h00, 1'b0, -1, 1'b0);

    cur_req = "R8 lose to lower address";
    txn(8'h19, 1'b1, 1'b1, {7'h28, 1'b1}, 1'b0, -1, 1'b0);
    cur_req = "R8 retry alone wins";
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, -1, 1'b0);

    cur_req = "R8 win over higher address";
    pulse_evt(3'b001);
    txn(8'h19, 1'b1, 1'b1, {7'h2B, 1'b1}, 1'b0, -1, 1'b0);

    cur_req = "R9 abort by stop";
    pulse_evt(3'b100);
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, 7, 1'b0);
    cur_req = "R9 abort by start";
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, 5, 1'b1);
    cur_req = "R9 retry after abort";
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, -1, 1'b0);

    cur_req = "R10 event at clear edge";
    pulse_evt(3'b010);
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b1, -1, 1'b0);
    cur_req = "R10 later read clears";
    txn(8'h19, 1'b1, 1'b0, 8'h00, 1'b0, -1, 1'b0);
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule